// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the line and frame timing for a progressive-scan analog monitor fed by a triple 8-bit video DAC. A horizontal counter runs on the pixel clock, and a vertical counter advances once per line. Each axis passes through four segments in a fixed order: sync, back porch, active, front porch. The length of every segment is a parameter counted in pixel clocks or in lines. The default mode is 1280x1024 at 60 Hz: 1688 clocks per line and 1066 lines per frame, at a pixel clock of about 108 MHz.

During the active area the block raises a pixel-request strobe and gives the zero-based column and row of the pixel it wants. The frame-buffer read controller fetches that pixel and presents it on `pixIn`. The block registers the pixel onto the 24-bit colour output. The separate syncs, the composite sync and the blanking control follow a pipeline of the same depth as the fetch, so the control outputs and the colour data reach the DAC together. Outside the active area the colour output is forced to zero.

Top module: `rasterTimingGen`

## Requirements
- R1: A synchronous reset (rst high) sets hSyncN, vSyncN, cSyncN, blankN, rgbOut, pixReq, frameEnd, pixCol and pixRow all to 0. The first clock after release continues from column count 0, line 0, which is the first clock of the horizontal sync segment.
- R2: A line is HS+HB+HA+HF clocks long, with the segments in the order sync, back porch, active, front porch. hSyncN is low (negative polarity) for exactly the HS clocks of the sync segment and high otherwise.
- R3: A frame is VS+VB+VA+VF lines long, in the same segment order. vSyncN is low for exactly the VS lines of the vertical sync segment. It falls on the same clock as hSyncN at the start of line 0.
- R4: cSyncN is low whenever hSyncN or vSyncN is low, so it equals hSyncN AND vSyncN on every clock.
- R5: blankN is high only when both axes are in their active segment. While blankN is low, rgbOut is 0 whatever pixIn carries.
- R6: frameEnd is high for exactly one clock, on the last clock of the last line. It recurs every frame.
- R7: pixReq is high exactly while the counters are in the active area. hSyncN, vSyncN, cSyncN and blankN show the counter state FETCH_LAT clocks late. rgbOut on clock t+FETCH_LAT equals the pixIn value presented on clock t+FETCH_LAT-1 for a request made on clock t. The channel order is {red[23:16], green[15:8], blue[7:0]}.
- R8: While pixReq is high, pixCol runs from 0 to HA-1 along the line and pixRow from 0 to VA-1 down the frame. While pixReq is low, both are 0.
- R9: A reset asserted in the middle of a frame returns every output to the R1 state. After release, timing starts again from line 0 with no leftover of the frame it cut off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pixIn | input | 24 | Fetched pixel {R,G,B}, FETCH_LAT-1 clocks after its request |
| pixReq | output | 1 | Pixel request to the frame-buffer reader |
| pixCol | output | $clog2(HA) | Requested pixel column, zero-based |
| pixRow | output | $clog2(VA) | Requested pixel row, zero-based |
| frameEnd | output | 1 | One-clock pulse on the last clock of a frame |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| cSyncN | output | 1 | Composite sync to the DAC, active low |
| blankN | output | 1 | Blanking control to the DAC, low while blanked |
| rgbOut | output | 24 | Colour data to the DAC, zero while blanked |

## Verification
On the last clock of a frame, frameEnd, the horizontal wrap and the vertical wrap all happen together. The delayed syncs also still show the previous line's front porch on that clock. The bench runs through two full frame boundaries. It checks that the clock after each wrap starts line 0 and column 0 with vSyncN and hSyncN falling together FETCH_LAT clocks later. In the active area, a new request and the gating of the previous fetched pixel fall on the same clock. A pixel pattern that is never zero makes any gating slip of one clock show up as a wrong colour on rgbOut.

// File: rtl/rtgPkg.sv
package rtgPkg;
  // Per-clock segment flags from the counter stage (active high internally).
  typedef struct packed {
    logic hSync;
    logic vSync;
    logic active;
  } rtgStrobe_t;

  // DAC-side control word carried down the fetch-latency pipeline.
  typedef struct packed {
    logic hSyncN;
    logic vSyncN;
    logic cSyncN;
    logic blankN;
  } rtgVideoCtl_t;
endpackage

// File: rtl/rtgCtrl.sv
module rtgCtrl
  import rtgPkg::*;
#(
  parameter int HS = 112,
  parameter int HB = 248,
  parameter int HA = 1280,
  parameter int HF = 48,
  parameter int VS = 3,
  parameter int VB = 38,
  parameter int VA = 1024,
  parameter int VF = 1,
  localparam int CW = (HA > 1) ? $clog2(HA) : 1,
  localparam int RW = (VA > 1) ? $clog2(VA) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output rtgStrobe_t    strobe,
  output logic          frameEnd,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row
);
  localparam int HT   = HS + HB + HA + HF;
  localparam int VT   = VS + VB + VA + VF;
  localparam int HW   = $clog2(HT);
  localparam int VW   = $clog2(VT);
  localparam int HBEG = HS + HB;
  localparam int HEND = HBEG + HA;
  localparam int VBEG = VS + VB;
  localparam int VEND = VBEG + VA;

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic          lineWrap;
  logic          hAct, vAct;

  assign lineWrap = (hCnt == HW'(HT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineWrap) begin
      hCnt <= '0;
      vCnt <= (vCnt == VW'(VT - 1)) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  assign hAct = (int'(hCnt) >= HBEG) && (int'(hCnt) < HEND);
  assign vAct = (int'(vCnt) >= VBEG) && (int'(vCnt) < VEND);

  always_comb begin
    strobe.hSync  = (int'(hCnt) < HS);
    strobe.vSync  = (int'(vCnt) < VS);
    strobe.active = hAct && vAct;
    frameEnd      = lineWrap && (vCnt == VW'(VT - 1));
    col = strobe.active ? CW'(int'(hCnt) - HBEG) : '0;
    row = strobe.active ? RW'(int'(vCnt) - VBEG) : '0;
  end
endmodule

// File: rtl/rtgDatapath.sv
module rtgDatapath
  import rtgPkg::*;
#(
  parameter int FETCH_LAT = 1,
  parameter int PW        = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  rtgStrobe_t    strobe,
  input  logic [PW-1:0] pixIn,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          cSyncN,
  output logic          blankN,
  output logic [PW-1:0] rgbOut
);
  rtgVideoCtl_t stage [FETCH_LAT+1];

  always_comb begin
    stage[0].hSyncN = ~strobe.hSync;
    stage[0].vSyncN = ~strobe.vSync;
    stage[0].cSyncN = ~(strobe.hSync | strobe.vSync);
    stage[0].blankN = strobe.active;
  end

  for (genvar s = 1; s <= FETCH_LAT; s++) begin : gDelay
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  // The colour register loads on the edge where its control word reaches the output.
  always_ff @(posedge clk) begin
    if (rst)                        rgbOut <= '0;
    else if (stage[FETCH_LAT-1].blankN) rgbOut <= pixIn;
    else                            rgbOut <= '0;
  end

  assign hSyncN = stage[FETCH_LAT].hSyncN;
  assign vSyncN = stage[FETCH_LAT].vSyncN;
  assign cSyncN = stage[FETCH_LAT].cSyncN;
  assign blankN = stage[FETCH_LAT].blankN;
endmodule

// File: rtl/rasterTimingGen.sv
module rasterTimingGen
  import rtgPkg::*;
#(
  parameter int HS        = 112,
  parameter int HB        = 248,
  parameter int HA        = 1280,
  parameter int HF        = 48,
  parameter int VS        = 3,
  parameter int VB        = 38,
  parameter int VA        = 1024,
  parameter int VF        = 1,
  parameter int FETCH_LAT = 1,
  localparam int CW = (HA > 1) ? $clog2(HA) : 1,
  localparam int RW = (VA > 1) ? $clog2(VA) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [23:0]   pixIn,
  output logic          pixReq,
  output logic [CW-1:0] pixCol,
  output logic [RW-1:0] pixRow,
  output logic          frameEnd,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          cSyncN,
  output logic          blankN,
  output logic [23:0]   rgbOut
);
  rtgStrobe_t strobe;

  rtgCtrl #(
    .HS(HS), .HB(HB), .HA(HA), .HF(HF),
    .VS(VS), .VB(VB), .VA(VA), .VF(VF)
  ) uCtrl (
    .clk(clk), .rst(rst), .strobe(strobe),
    .frameEnd(frameEnd), .col(pixCol), .row(pixRow)
  );

  rtgDatapath #(.FETCH_LAT(FETCH_LAT), .PW(24)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .pixIn(pixIn),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .cSyncN(cSyncN),
    .blankN(blankN), .rgbOut(rgbOut)
  );

  assign pixReq = strobe.active;
endmodule

// File: rtl/rasterTimingGen_chk.sv
module rasterTimingGen_chk #(
  parameter int HA        = 1280,
  parameter int VA        = 1024,
  parameter int FETCH_LAT = 1,
  localparam int CW = (HA > 1) ? $clog2(HA) : 1,
  localparam int RW = (VA > 1) ? $clog2(VA) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          pixReq,
  input logic [CW-1:0] pixCol,
  input logic [RW-1:0] pixRow,
  input logic          frameEnd,
  input logic          hSyncN,
  input logic          vSyncN,
  input logic          cSyncN,
  input logic          blankN,
  input logic [23:0]   rgbOut
);
  logic [FETCH_LAT-1:0] reqTrail;

  always_ff @(posedge clk) begin
    if (rst) reqTrail <= '0;
    else     reqTrail <= (reqTrail << 1) | FETCH_LAT'(pixReq);
  end

  AST_CSYNC_AND: assert property (@(posedge clk) disable iff (rst)
    cSyncN == (hSyncN & vSyncN)); // R4
  AST_DARK_WHEN_BLANK: assert property (@(posedge clk) disable iff (rst)
    !blankN |-> rgbOut == 24'd0); // R5
  AST_BLANK_TRAILS_REQ: assert property (@(posedge clk) disable iff (rst)
    blankN == reqTrail[FETCH_LAT-1]); // R7
  AST_FRAME_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    frameEnd |=> !frameEnd); // R6
  AST_COORD_RANGE: assert property (@(posedge clk) disable iff (rst)
    pixReq |-> (int'(pixCol) < HA && int'(pixRow) < VA)); // R8
  AST_COORD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pixReq |-> (pixCol == '0 && pixRow == '0)); // R8
  AST_VSYNC_AT_LINE: assert property (@(posedge clk) disable iff (rst)
    $fell(vSyncN) |-> !hSyncN); // R3
endmodule

bind rasterTimingGen rasterTimingGen_chk #(
  .HA(HA), .VA(VA), .FETCH_LAT(FETCH_LAT)
) uChk (
  .clk(clk), .rst(rst), .pixReq(pixReq), .pixCol(pixCol), .pixRow(pixRow),
  .frameEnd(frameEnd), .hSyncN(hSyncN), .vSyncN(vSyncN), .cSyncN(cSyncN),
  .blankN(blankN), .rgbOut(rgbOut)
);

// File: tb/rasterTimingGen_test.sv
module rasterTimingGen_test;
  localparam int HS = 4, HB = 3, HA = 8, HF = 2;
  localparam int VS = 2, VB = 2, VA = 5, VF = 1;
  localparam int LAT = 2;
  localparam int HT = HS + HB + HA + HF;
  localparam int VT = VS + VB + VA + VF;
  localparam int FT = HT * VT;
  localparam int CW = $clog2(HA);
  localparam int RW = $clog2(VA);

  // Fields: cycle, pixReq, pixCol, pixRow, frameEnd, hSyncN, vSyncN, blankN
  localparam int NV = 10;
  localparam int VEC [NV][8] = '{
    '{ 34, 0, 0, 0, 0, 1, 0, 0},
    '{ 36, 0, 0, 0, 0, 0, 1, 0},
    '{ 38, 0, 0, 0, 0, 0, 1, 0},
    '{ 40, 0, 0, 0, 0, 1, 1, 0},
    '{ 75, 1, 0, 0, 0, 1, 1, 0},
    '{ 77, 1, 2, 0, 0, 1, 1, 1},
    '{150, 1, 7, 4, 0, 1, 1, 1},
    '{169, 0, 0, 0, 1, 1, 1, 0},
    '{170, 0, 0, 0, 0, 1, 1, 0},
    '{172, 0, 0, 0, 0, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0]   pixIn = '0;
  logic          pixReq, frameEnd, hSyncN, vSyncN, cSyncN, blankN;
  logic [CW-1:0] pixCol;
  logic [RW-1:0] pixRow;
  logic [23:0]   rgbOut;

  int checks = 0;
  int errors = 0;
  int k = 0;

  always #5 clk = ~clk;

  rasterTimingGen #(
    .HS(HS), .HB(HB), .HA(HA), .HF(HF),
    .VS(VS), .VB(VB), .VA(VA), .VF(VF), .FETCH_LAT(LAT)
  ) uut (
    .clk(clk), .rst(rst), .pixIn(pixIn), .pixReq(pixReq),
    .pixCol(pixCol), .pixRow(pixRow), .frameEnd(frameEnd),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .cSyncN(cSyncN),
    .blankN(blankN), .rgbOut(rgbOut)
  );

  function automatic logic [23:0] pat(int j);
    return {8'(j * 7) | 8'h01, 8'(j) ^ 8'hA5, 8'(j * 3) | 8'h80};
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %0h expected %0h", req, what, k, got, exp);
    end
  endtask

  task automatic finishUp();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic checkResetState(input string req);
    chk(req, "hSyncN", int'(hSyncN), 0);
    chk(req, "vSyncN", int'(vSyncN), 0);
    chk(req, "cSyncN", int'(cSyncN), 0);
    chk(req, "blankN", int'(blankN), 0);
    chk(req, "rgbOut", int'(rgbOut), 0);
    chk(req, "pixReq", int'(pixReq), 0);
    chk(req, "frameEnd", int'(frameEnd), 0);
    chk(req, "pixCol", int'(pixCol), 0);
    chk(req, "pixRow", int'(pixRow), 0);
  endtask

  // Independent model of every output for k clocks since reset release.
  task automatic modelCheck();
    int pos, h, v, dk, dh, dv;
    bit act, dact;
    pos  = k % FT;  h = pos % HT;  v = pos / HT;
    act  = (h >= HS + HB) && (h < HS + HB + HA) && (v >= VS + VB) && (v < VS + VB + VA);
    dk   = (k >= LAT) ? k - LAT : 0;
    dh   = (dk % FT) % HT;  dv = (dk % FT) / HT;
    dact = (dh >= HS + HB) && (dh < HS + HB + HA) && (dv >= VS + VB) && (dv < VS + VB + VA);
    chk("R7", "pixReq", int'(pixReq), int'(act));
    chk("R8", "pixCol", int'(pixCol), act ? h - (HS + HB) : 0);
    chk("R8", "pixRow", int'(pixRow), act ? v - (VS + VB) : 0);
    chk("R6", "frameEnd", int'(frameEnd), int'(pos == FT - 1));
    chk("R2", "hSyncN", int'(hSyncN), int'(!(dh < HS)));
    chk("R3", "vSyncN", int'(vSyncN), int'(!(dv < VS)));
    chk("R4", "cSyncN", int'(cSyncN), int'(!(dh < HS) && !(dv < VS)));
    chk("R5", "blankN", int'(blankN), int'(dact));
    chk("R7", "rgbOut", int'(rgbOut), (k >= LAT && dact) ? int'(pat(k - 1)) : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d: got hang expected finish", k);
    finishUp();
  end

  initial begin
    int vi;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkResetState("R1");
    pixIn = pat(0);
    rst = 1'b0;
    k = 0;
    vi = 0;
    // Vector table walk plus a full model comparison over two frames.
    for (int c = 1; c <= 2 * FT + 6; c++) begin
      @(posedge clk);
      k = c;
      @(negedge clk);
      modelCheck();
      if (vi < NV && VEC[vi][0] == k) begin
        chk("R7", "vec pixReq", int'(pixReq), VEC[vi][1]);
        chk("R8", "vec pixCol", int'(pixCol), VEC[vi][2]);
        chk("R8", "vec pixRow", int'(pixRow), VEC[vi][3]);
        chk("R6", "vec frameEnd", int'(frameEnd), VEC[vi][4]);
        chk("R2", "vec hSyncN", int'(hSyncN), VEC[vi][5]);
        chk("R3", "vec vSyncN", int'(vSyncN), VEC[vi][6]);
        chk("R5", "vec blankN", int'(blankN), VEC[vi][7]);
        vi++;
      end
      pixIn = pat(k);
    end
    chk("R2", "vector table consumed", vi, NV);

    // Mid-frame reset in the middle of an active line (R9).
    while (!(pixReq && blankN)) begin
      @(posedge clk);
      @(negedge clk);
    end
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkResetState("R9");
    rst = 1'b0;
    k = 0;
    pixIn = pat(0);
    for (int c = 1; c <= FT + LAT + 2; c++) begin
      @(posedge clk);
      k = c;
      @(negedge clk);
      modelCheck();
      pixIn = pat(k);
    end
    finishUp();
  end
endmodule